// File: doc/BRIEF.md
# Interrupt Enable Register Bank with Set/Clear Aliases

The block holds a small bank of interrupt control registers behind a 32-bit valid/ready register bus. Every register appears at two addresses. A write to the set address ORs the written bits into the stored value. A write to the clear address removes the written bits from it. Some registers are mask registers, with one bit per interrupt source. The others are priority registers, divided into equal-width fields with one field per source. A read from either address returns the stored value.

After each write, the block compares every bit or field of the old value with the new one. For each bit or field that changed, it issues one event for the source mapped to that position. The event is a grant when the new value is nonzero and a revoke when it is zero. A position can instead map to a group identifier. In that case the event is handed along the group's member chain, and every member receives it. Events leave the block one per cycle, and the bus stalls until the last event has been issued. The logic that tracks pending interrupts consumes these events and is not part of this block.

Top module: `intc_mask_bank`

## Requirements
- R1: A write to the set address of register r stores old | wdata[REG_W-1:0]. The default mapping places register r's set address at 0x0400_0000 + 8*r. Registers 0 and 1 are mask registers and register 2 is a priority register with 4-bit fields.
- R2: A write to the clear address of register r (the set address + 4) stores old & ~wdata[REG_W-1:0].
- R3: Address bits [31:29] take no part in decoding. Only bits [28:0] are compared.
- R4: A read from either address of a register returns its stored value, zero-extended, with rsp_valid_o high. A read from an unmapped address returns 0. A write to an unmapped address changes no register and raises no event.
- R5: In a mask register, position 0 is bit REG_W-1, position 1 is the next bit down, and so on. Default source IDs: register 0 maps positions 0..7 to IDs 1,2,3,4,5,6,7,0. Register 1 maps them to 8,9,10,15,0,0,0,0. Changed positions are handled in ascending position order, one cycle each.
- R6: A priority register has REG_W/FIELD_W fields, and field 0 is the most significant. Default IDs for register 2 are 13 (bits 7:4) and 14 (bits 3:0).
- R7: Each changed bit or field raises evt_grant_o=1 if its new value is nonzero and evt_grant_o=0 if it is zero. A field that changes from one nonzero value to another also raises a grant. Unchanged positions raise nothing, and a write that changes nothing does not stall.
- R8: ID 0 never raises an event. An ID that is neither a source nor a group head (default: ID 15) also raises none. The default sources are IDs 1..7 and 9..14.
- R9: If a changed position maps to a non-source ID with a successor, the event is passed down the successor chain and every source on the chain receives it. Default chain: 8→11→12. A source reached directly from its own position does not pass the event to its successor. By default, 9 has successor 13, which receives nothing.
- R10: Out of reset, every register is 0, req_ready_o is 1 and no event is raised. req_ready_o is low from the cycle after a write that changes a position until the cycle in which its last event appears.
- R11: Read data and rsp_valid_o appear in the cycle after the read is accepted, and never together with an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Bus request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 32 | Write data |
| req_ready_o | output | 1 | Request accepted this cycle when high with valid |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| evt_valid_o | output | 1 | Enable event valid |
| evt_grant_o | output | 1 | 1 = grant, 0 = revoke |
| evt_id_o | output | ID_W | Source ID of the event |

## Verification
The assertions assume that a requester keeps req_valid_i and its fields steady until req_ready_o accepts them. They also assume the successor chain in the ID tables has no loop; a loop would stall the bus forever. The bench holds each request until it is accepted and drops it in the following cycle. It uses only the default tables, whose chains are finite. Random addresses mix all aliases, random top bits and one unmapped slot, and random data touches every position.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic {ST_IDLE, ST_WALK} walk_state_e;
endpackage

// File: rtl/intc_addr_dec.sv
module intc_addr_dec #(
  parameter int          N_REG  = 3,
  parameter logic [31:0] BASE   = 32'h0400_0000,
  parameter int          RIDX_W = 2
) (
  input  logic [31:0]       addr_i,
  output logic              hit_o,
  output logic              clr_o,
  output logic [RIDX_W-1:0] idx_o
);
  logic unused_top;
  assign unused_top = ^addr_i[31:29];

  always_comb begin
    hit_o = 1'b0;
    clr_o = 1'b0;
    idx_o = '0;
    for (int r = 0; r < N_REG; r++) begin
      logic [31:0] sa;
      sa = BASE + 32'(r * 8);
      if (addr_i[28:0] == sa[28:0]) begin
        hit_o = 1'b1;
        idx_o = RIDX_W'(r);
      end
      if (addr_i[28:0] == sa[28:0] + 29'd4) begin
        hit_o = 1'b1;
        clr_o = 1'b1;
        idx_o = RIDX_W'(r);
      end
    end
  end
endmodule

// File: rtl/intc_reg_bank.sv
module intc_reg_bank #(
  parameter int N_REG   = 3,
  parameter int N_MASK  = 2,
  parameter int REG_W   = 8,
  parameter int FIELD_W = 4,
  parameter int RIDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              clr_i,
  input  logic [RIDX_W-1:0] idx_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [REG_W-1:0]  chg_o,
  output logic [REG_W-1:0]  nz_o
);
  localparam int PF = REG_W / FIELD_W;

  logic [REG_W-1:0] regs_q [N_REG];
  logic [REG_W-1:0] old_v, new_v, chg_m, nz_m, chg_p, nz_p;
  logic             is_prio;

  assign old_v   = regs_q[idx_i];
  assign new_v   = clr_i ? (old_v & ~wdata_i) : (old_v | wdata_i);
  assign rdata_o = old_v;
  assign is_prio = int'(idx_i) >= N_MASK;

  for (genvar f = 0; f < REG_W; f++) begin : g_pos
    assign chg_m[f] = old_v[REG_W-1-f] ^ new_v[REG_W-1-f];
    assign nz_m[f]  = new_v[REG_W-1-f];
    if (f < PF) begin : g_fld
      assign chg_p[f] = old_v[(PF-1-f)*FIELD_W +: FIELD_W] != new_v[(PF-1-f)*FIELD_W +: FIELD_W];
      assign nz_p[f]  = |new_v[(PF-1-f)*FIELD_W +: FIELD_W];
    end else begin : g_nofld
      assign chg_p[f] = 1'b0;
      assign nz_p[f]  = 1'b0;
    end
  end

  assign chg_o = is_prio ? chg_p : chg_m;
  assign nz_o  = is_prio ? nz_p : nz_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < N_REG; r++) regs_q[r] <= '0;
    end else if (wr_en_i) begin
      regs_q[idx_i] <= new_v;
    end
  end
endmodule

// File: rtl/intc_evt_walker.sv
module intc_evt_walker
  import intc_pkg::*;
#(
  parameter int N_MASK  = 2,
  parameter int N_PRIO  = 1,
  parameter int REG_W   = 8,
  parameter int FIELD_W = 4,
  parameter int ID_W    = 4,
  parameter int RIDX_W  = 2,
  parameter logic [N_MASK*REG_W*ID_W-1:0]          MASK_IDS = '0,
  parameter logic [N_PRIO*(REG_W/FIELD_W)*ID_W-1:0] PRIO_IDS = '0,
  parameter logic [(1<<ID_W)-1:0]                  SRC_MAP  = '0,
  parameter logic [(1<<ID_W)*ID_W-1:0]             NEXT_MAP = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RIDX_W-1:0] idx_i,
  input  logic [REG_W-1:0]  chg_i,
  input  logic [REG_W-1:0]  nz_i,
  output logic              busy_o,
  output logic              evt_valid_o,
  output logic              evt_grant_o,
  output logic [ID_W-1:0]   evt_id_o
);
  localparam int PF = REG_W / FIELD_W;
  localparam int FW = (REG_W > 1) ? $clog2(REG_W) : 1;

  walk_state_e       state_q;
  logic [RIDX_W-1:0] ridx_q;
  logic [REG_W-1:0]  chg_q, nz_q, chg_nx;
  logic              chain_q, chain_en_q;
  logic [ID_W-1:0]   chain_id_q;

  logic [FW-1:0]     first;
  logic [ID_W-1:0]   fld_id, sel_id, nxt_id;
  logic              emit, follow, en;

  always_comb begin
    first = '0;
    for (int f = REG_W - 1; f >= 0; f--) if (chg_q[f]) first = FW'(f);
  end

  always_comb begin
    if (int'(ridx_q) < N_MASK)
      fld_id = MASK_IDS[(int'(ridx_q) * REG_W + int'(first)) * ID_W +: ID_W];
    else
      fld_id = PRIO_IDS[((int'(ridx_q) - N_MASK) * PF + int'(first)) * ID_W +: ID_W];
  end

  assign sel_id = chain_q ? chain_id_q : fld_id;
  assign en     = chain_q ? chain_en_q : nz_q[first];
  assign nxt_id = NEXT_MAP[int'(sel_id) * ID_W +: ID_W];
  assign emit   = (sel_id != '0) && SRC_MAP[sel_id];
  // a source only forwards when reached through a group chain
  assign follow = (sel_id != '0) && (nxt_id != '0) && (chain_q || !SRC_MAP[sel_id]);
  assign chg_nx = chain_q ? chg_q : (chg_q & ~(REG_W'(1) << first));
  assign busy_o = (state_q == ST_WALK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      ridx_q      <= '0;
      chg_q       <= '0;
      nz_q        <= '0;
      chain_q     <= 1'b0;
      chain_en_q  <= 1'b0;
      chain_id_q  <= '0;
      evt_valid_o <= 1'b0;
      evt_grant_o <= 1'b0;
      evt_id_o    <= '0;
    end else if (state_q == ST_IDLE) begin
      evt_valid_o <= 1'b0;
      if (start_i) begin
        state_q <= ST_WALK;
        ridx_q  <= idx_i;
        chg_q   <= chg_i;
        nz_q    <= nz_i;
        chain_q <= 1'b0;
      end
    end else begin
      chg_q       <= chg_nx;
      evt_valid_o <= emit;
      evt_grant_o <= en;
      evt_id_o    <= sel_id;
      chain_q     <= follow;
      if (follow) begin
        chain_id_q <= nxt_id;
        chain_en_q <= en;
      end
      if (!follow && chg_nx == '0) state_q <= ST_IDLE;
    end
  end
endmodule

// File: rtl/intc_mask_bank.sv
module intc_mask_bank #(
  parameter int          N_MASK  = 2,
  parameter int          N_PRIO  = 1,
  parameter int          REG_W   = 8,
  parameter int          FIELD_W = 4,
  parameter int          ID_W    = 4,
  parameter logic [31:0] BASE    = 32'h0400_0000,
  parameter logic [N_MASK*REG_W*ID_W-1:0]          MASK_IDS = 64'h0000_FA98_0765_4321,
  parameter logic [N_PRIO*(REG_W/FIELD_W)*ID_W-1:0] PRIO_IDS = 8'hED,
  parameter logic [(1<<ID_W)-1:0]                  SRC_MAP  = 16'h7EFE,
  parameter logic [(1<<ID_W)*ID_W-1:0]             NEXT_MAP = 64'h0000_C0DB_0000_0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic            req_write_i,
  input  logic [31:0]     req_addr_i,
  input  logic [31:0]     req_wdata_i,
  output logic            req_ready_o,
  output logic            rsp_valid_o,
  output logic [31:0]     rsp_rdata_o,
  output logic            evt_valid_o,
  output logic            evt_grant_o,
  output logic [ID_W-1:0] evt_id_o
);
  localparam int N_REG  = N_MASK + N_PRIO;
  localparam int RIDX_W = (N_REG > 1) ? $clog2(N_REG) : 1;

  logic              hit, clr, acc, wr_en, busy;
  logic [RIDX_W-1:0] idx;
  logic [REG_W-1:0]  rd, chg, nz;
  logic              unused_wdata;

  assign unused_wdata = ^req_wdata_i[31:REG_W];
  assign req_ready_o  = !busy;
  assign acc          = req_valid_i && req_ready_o;
  assign wr_en        = acc && req_write_i && hit;

  intc_addr_dec #(.N_REG(N_REG), .BASE(BASE), .RIDX_W(RIDX_W)) u_dec (
    .addr_i(req_addr_i), .hit_o(hit), .clr_o(clr), .idx_o(idx)
  );

  intc_reg_bank #(
    .N_REG(N_REG), .N_MASK(N_MASK), .REG_W(REG_W), .FIELD_W(FIELD_W), .RIDX_W(RIDX_W)
  ) u_bank (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .clr_i(clr), .idx_i(idx),
    .wdata_i(req_wdata_i[REG_W-1:0]), .rdata_o(rd), .chg_o(chg), .nz_o(nz)
  );

  intc_evt_walker #(
    .N_MASK(N_MASK), .N_PRIO(N_PRIO), .REG_W(REG_W), .FIELD_W(FIELD_W), .ID_W(ID_W),
    .RIDX_W(RIDX_W), .MASK_IDS(MASK_IDS), .PRIO_IDS(PRIO_IDS), .SRC_MAP(SRC_MAP),
    .NEXT_MAP(NEXT_MAP)
  ) u_walk (
    .clk_i, .rst_ni, .start_i(wr_en && (chg != '0)), .idx_i(idx), .chg_i(chg), .nz_i(nz),
    .busy_o(busy), .evt_valid_o, .evt_grant_o, .evt_id_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= acc && !req_write_i;
      if (acc && !req_write_i) rsp_rdata_o <= hit ? 32'(rd) : 32'd0;
    end
  end
endmodule

// File: rtl/intc_mask_bank_chk.sv
module intc_mask_bank_chk #(
  parameter int ID_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_write_i,
  input logic            req_ready_o,
  input logic            rsp_valid_o,
  input logic            evt_valid_o,
  input logic [ID_W-1:0] evt_id_o
);
  assert_evt_id_nonzero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> evt_id_o != '0);

  assert_evt_only_while_stalled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> $past(!req_ready_o));

  assert_stall_follows_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_ready_o) |-> $past(req_valid_i && req_write_i));

  assert_rsp_after_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_valid_i && req_ready_o && !req_write_i));

  assert_rsp_not_with_evt_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && evt_valid_o));
endmodule

bind intc_mask_bank intc_mask_bank_chk #(.ID_W(ID_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
  .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o), .evt_valid_o(evt_valid_o),
  .evt_id_o(evt_id_o)
);

// File: tb/sim_intc_mask_bank.sv
`timescale 1ns/1ps
module sim_intc_mask_bank;
  localparam logic [31:0] BASE = 32'h0400_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid, evt_valid, evt_grant;
  logic [31:0] rsp_rdata;
  logic [3:0]  evt_id;

  int checks = 0, fails = 0;
  logic [7:0] mreg [3];
  logic [4:0] exp_q[$], got_q[$];

  always #4 clk = ~clk;

  intc_mask_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .evt_valid_o(evt_valid),
    .evt_grant_o(evt_grant), .evt_id_o(evt_id)
  );

  always @(negedge clk) if (evt_valid) got_q.push_back({evt_grant, evt_id});

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] fid(input int r, input int f);
    logic [3:0] t0 [8] = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd0};
    logic [3:0] t1 [8] = '{4'd8, 4'd9, 4'd10, 4'd15, 4'd0, 4'd0, 4'd0, 4'd0};
    if (r == 0) return t0[f];
    if (r == 1) return t1[f];
    return (f == 0) ? 4'd13 : 4'd14;
  endfunction

  function automatic bit is_src(input logic [3:0] id);
    return (id >= 1 && id <= 7) || (id >= 9 && id <= 14);
  endfunction

  function automatic logic [3:0] nxt(input logic [3:0] id);
    case (id)
      4'd8: return 4'd11;
      4'd11: return 4'd12;
      4'd9: return 4'd13;
      default: return 4'd0;
    endcase
  endfunction

  function automatic int decode(input logic [31:0] a, output bit clr);
    clr = 0;
    for (int r = 0; r < 3; r++) begin
      logic [31:0] sa;
      sa = BASE + 32'(r * 8);
      if (a[28:0] == sa[28:0]) return r;
      if (a[28:0] == sa[28:0] + 29'd4) begin clr = 1; return r; end
    end
    return -1;
  endfunction

  task automatic model_write(input logic [31:0] a, input logic [31:0] d);
    bit clr;
    int r;
    logic [7:0] o, n;
    r = decode(a, clr);
    if (r < 0) return;
    o = mreg[r];
    n = clr ? (o & ~d[7:0]) : (o | d[7:0]);
    mreg[r] = n;
    for (int f = 0; f < ((r == 2) ? 2 : 8); f++) begin
      bit ch, nzv, chain;
      logic [3:0] cur;
      if (r == 2) begin
        ch  = o[(1-f)*4 +: 4] != n[(1-f)*4 +: 4];
        nzv = |n[(1-f)*4 +: 4];
      end else begin
        ch  = o[7-f] ^ n[7-f];
        nzv = n[7-f];
      end
      if (!ch) continue;
      cur = fid(r, f);
      chain = 0;
      while (cur != 0) begin
        if (is_src(cur)) exp_q.push_back({nzv, cur});
        if (nxt(cur) == 0 || (!chain && is_src(cur))) break;
        cur = nxt(cur);
        chain = 1;
      end
    end
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d, input string tag,
                          input bit chk_stall = 0);
    exp_q.delete();
    got_q.delete();
    model_write(a, d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0;
    if (chk_stall) check(req_ready == 1'b0, {tag, " R10 stall"}, 32'(req_ready), 32'd0);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    check(got_q.size() == exp_q.size(), {tag, " event count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], {tag, " event"}, 32'(got_q[i]), 32'(exp_q[i]));
  endtask

  task automatic do_read(input logic [31:0] a, input string tag);
    bit clr;
    int r;
    logic [31:0] e;
    r = decode(a, clr);
    e = (r < 0) ? 32'd0 : 32'(mreg[r]);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid == 1'b1, {tag, " R11 rsp_valid"}, 32'(rsp_valid), 32'd1);
    check(rsp_rdata == e, {tag, " R4 rdata"}, rsp_rdata, e);
  endtask

  initial begin
    #(8ns * 150000);
    fails++;
    $display("FAIL watchdog R10 actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int r = 0; r < 3; r++) mreg[r] = '0;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R10 reset ready", 32'(req_ready), 32'd1);
    check(evt_valid == 1'b0, "R10 reset evt", 32'(evt_valid), 32'd0);
    rst_n = 1;
    do_read(BASE, "R10 reset reg0");
    do_read(BASE + 32'h14, "R10 reset reg2");
    do_write(BASE, 32'h81, "R5 R8 msb and reserved id0");
    do_read(BASE + 32'h4, "R4 read via clear alias");
    do_write(BASE, 32'h06, "R5 order", 1);
    do_read(BASE, "R1 set OR");
    do_write(32'hE400_0004, 32'h80, "R2 R3 clear via top bits");
    do_read(32'h2400_0000, "R3 read alias top bits");
    do_write(BASE + 32'h8, 32'h80, "R9 group fanout", 1);
    do_write(BASE + 32'h8, 32'h40, "R9 direct source no forward");
    do_write(BASE + 32'h8, 32'h10, "R8 id15 no event");
    do_read(BASE + 32'hC, "R4 reg1 value");
    do_write(BASE + 32'hC, 32'h80, "R9 R7 group revoke");
    do_write(BASE + 32'h10, 32'h30, "R6 prio field0 grant");
    do_write(BASE + 32'h10, 32'h40, "R7 nonzero to nonzero grant");
    do_write(BASE + 32'h14, 32'h70, "R6 R7 prio revoke");
    do_write(BASE + 32'h10, 32'h05, "R6 field1");
    do_write(BASE, 32'h00, "R7 no change no stall");
    do_write(BASE + 32'h40, 32'hFF, "R4 unmapped write");
    do_read(BASE + 32'h40, "R4 unmapped read");
    do_read(BASE, "R4 regs unchanged after unmapped");
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      int sel;
      sel = int'($urandom % 4);
      a = BASE + 32'(sel * 8) + (($urandom % 2) != 0 ? 32'd4 : 32'd0);
      a[31:29] = 3'($urandom);
      if (($urandom % 2) != 0) do_write(a, $urandom, "R1 R2 R7 random write");
      else do_read(a, "R4 random read");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule